// File: doc/BRIEF.md
# DMA Page-Table Walker

This block turns a 64-bit device DMA address into a system address. Each request carries the address, an endpoint number and a read/write flag. The block works out which of two window descriptors applies to that endpoint. It reads that descriptor through a lookup port. Depending on the descriptor, the block does one of three things: it passes the address straight through, it rejects the request, or it walks an in-memory table of up to five levels, fetching one 64-bit word per level.

The walker returns one of two results. On success it gives the translated page address, the offset mask and the granted permissions. Otherwise it reports a fault. Table words come in over a simple request/response memory read port and are stored big-endian. The walker handles one translation at a time.

Descriptor fields:
- table base: bits 39:0, counted in 4 KiB units
- level count: bits 42:40
- index-width field: bits 47:43
- pass-through enable: bit 51
- page-size field: bits 56:52

Top module: `dma_page_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: For an address whose bits 63:60 are zero, the descriptor used is the one at index endpoint*2 + address bit 59. That index is driven on `tve_idx`.
- R3: The following requests fault without any memory fetch:
  - address bits 63:60 equal to 1 (64-bit message window);
  - any other nonzero value of bits 63:60;
  - `msi32_en` set and address bits 63:16 equal to 0xFFFF.
  Every fault response has `rsp_addr`, `rsp_mask` and `rsp_perm` at zero.
- R4: A level count above 4 faults without a fetch.
- R5: When the page-size field is zero and bit 51 is set, the result is: the address with bits 63:50 and 11:0 cleared, mask 0xFFF, permission 3, and no fetch. When the page-size field is zero and bit 51 is clear, the request faults.
- R6: A nonzero page-size field with a zero index-width field faults without a fetch.
- R7: A walk uses these values:
  - page shift P = page-size field + 11;
  - index width W = index-width field + 8;
  - starting shift S = W*levels + P;
  - first base = table base << 12.

  Each fetch reads base | (((addr >> S) & (2^W-1)) << 3), and S then drops by W. There are levels+1 fetches in all. A pending fetch holds its address until it is accepted.
- R8: A non-final word with bits 1:0 equal to 0 ends the walk with a fault. Otherwise the word with bits 11:0 cleared becomes the next base.
- R9: In the final word, bit 0 grants read and bit 1 grants write. An access without its bit faults.
- R10: On success, the results are:
  - `rsp_addr` = final word with bits P-1:0 cleared;
  - `rsp_mask` = 2^P-1;
  - `rsp_perm` = final word bits 1:0.
- R11: An error response on any fetch ends the walk with a fault.
- R12: Once a request is accepted, `req_ready` stays low until the response. The response is a single-cycle `rsp_valid` pulse, and no fetch is issued while idle.
- R13: A table word arriving on `mem_rsp_data` has its most significant byte in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_addr | input | 64 | DMA address |
| req_pe | input | PE_W | Endpoint number |
| req_write | input | 1 | 1 for a write access |
| msi32_en | input | 1 | Reject the 32-bit message window |
| tve_idx | output | PE_W+1 | Descriptor index |
| tve_data | input | 64 | Descriptor at `tve_idx` |
| mem_req_valid | output | 1 | Table fetch request |
| mem_req_ready | input | 1 | Fetch accepted |
| mem_req_addr | output | 64 | Fetch address |
| mem_rsp_valid | input | 1 | Fetch data present |
| mem_rsp_err | input | 1 | Fetch failed |
| mem_rsp_data | input | 64 | Fetched word, big-endian bytes |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_addr | output | 64 | Translated page address |
| rsp_mask | output | 64 | Page offset mask |
| rsp_perm | output | 2 | Bit 1 write, bit 0 read |

## Verification
A wrong walk shift, index width or level counter shows up on `mem_req_addr` at the fetch where it goes wrong. It also changes the number of fetches before `rsp_valid`. The bench compares every fetch address against its own model, so such an error is caught within one table level. A corrupted base or wrong byte order makes the walk leave the bench's sparse memory. That produces an error response and a fault outcome that differs from the expected one, within the same translation. Faults in decode or permissions show up on the single result pulse.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
    localparam int ENT_W      = 64;
    localparam int BASE_LO    = 0;
    localparam int BASE_HI    = 39;
    localparam int LEV_LO     = 40;
    localparam int LEV_HI     = 42;
    localparam int WID_LO     = 43;
    localparam int WID_HI     = 47;
    localparam int PASS_BIT   = 51;
    localparam int PSZ_LO     = 52;
    localparam int PSZ_HI     = 56;
    localparam int MAX_LEV    = 4;
    localparam int PSH_OFS    = 11;
    localparam int WID_OFS    = 8;
    localparam int SH_W       = 8;
    localparam int FLD_W      = 6;

    typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_FETCH, ST_WAIT, ST_RESP} walk_st_e;
    typedef enum logic [1:0] {DEC_FAULT, DEC_PASS, DEC_WALK} dec_kind_e;
endpackage

// File: rtl/dpw_tve_decode.sv
module dpw_tve_decode
    import dpw_pkg::*;
(
    input  logic [63:0]      addr,
    input  logic [ENT_W-1:0] entry,
    input  logic             msi32_en,
    output dec_kind_e        kind,
    output logic [2:0]       levels,
    output logic [FLD_W-1:0] pshift,
    output logic [FLD_W-1:0] width,
    output logic [SH_W-1:0]  shift0,
    output logic [63:0]      base0,
    output logic [63:0]      pass_addr
);
    logic [4:0] psz;
    logic [4:0] wfld;

    always_comb begin
        psz       = entry[PSZ_HI:PSZ_LO];
        wfld      = entry[WID_HI:WID_LO];
        levels    = entry[LEV_HI:LEV_LO];
        pshift    = FLD_W'(psz) + FLD_W'(PSH_OFS);
        width     = FLD_W'(wfld) + FLD_W'(WID_OFS);
        shift0    = SH_W'(width) * SH_W'(levels) + SH_W'(pshift);
        base0     = 64'(entry[BASE_HI:BASE_LO]) << 12;
        pass_addr = addr & 64'h0003_ffff_ffff_f000;
        if (addr[63:60] != 4'h0)
            kind = DEC_FAULT;
        else if (msi32_en && addr[63:16] == 48'h0000_0000_ffff)
            kind = DEC_FAULT;
        else if (int'(levels) > MAX_LEV)
            kind = DEC_FAULT;
        else if (psz == 5'd0)
            kind = entry[PASS_BIT] ? DEC_PASS : DEC_FAULT;
        else if (wfld == 5'd0)
            kind = DEC_FAULT;
        else
            kind = DEC_WALK;
    end
endmodule

// File: rtl/dpw_fetch_addr.sv
module dpw_fetch_addr
    import dpw_pkg::*;
(
    input  logic [63:0]      base,
    input  logic [63:0]      addr,
    input  logic [SH_W-1:0]  shift,
    input  logic [FLD_W-1:0] width,
    output logic [63:0]      fetch_addr
);
    logic [63:0] idx;

    always_comb begin
        idx        = (addr >> shift) & ((64'd1 << width) - 64'd1);
        fetch_addr = base | (idx << 3);
    end
endmodule

// File: rtl/dpw_byteswap.sv
module dpw_byteswap #(
    parameter int BYTES = 8
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign dout[8*g +: 8] = din[8*(BYTES-1-g) +: 8];
    end
endmodule

// File: rtl/dma_page_walker.sv
module dma_page_walker
    import dpw_pkg::*;
#(
    parameter int PE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_addr,
    input  logic [PE_W-1:0]   req_pe,
    input  logic              req_write,
    input  logic              msi32_en,
    output logic [PE_W:0]     tve_idx,
    input  logic [ENT_W-1:0]  tve_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [63:0]       rsp_addr,
    output logic [63:0]       rsp_mask,
    output logic [1:0]        rsp_perm
);
    localparam int BYTES = ENT_W / 8;

    typedef struct packed {
        walk_st_e         st;
        logic [63:0]      addr;
        logic             wr;
        logic [PE_W-1:0]  pe;
        logic [63:0]      base;
        logic [SH_W-1:0]  shift;
        logic [FLD_W-1:0] width;
        logic [FLD_W-1:0] pshift;
        logic [2:0]       left;
        logic             fault;
        logic [63:0]      res_addr;
        logic [63:0]      res_mask;
        logic [1:0]       res_perm;
    } walk_t;

    walk_t q, d;

    dec_kind_e        dec_kind;
    logic [2:0]       dec_lev;
    logic [FLD_W-1:0] dec_psh;
    logic [FLD_W-1:0] dec_wid;
    logic [SH_W-1:0]  dec_sh;
    logic [63:0]      dec_base;
    logic [63:0]      dec_pass;
    logic [ENT_W-1:0] word;
    logic [63:0]      page_mask;
    logic             granted;

    assign tve_idx = {q.pe, q.addr[59]};

    dpw_tve_decode dec_i (
        .addr(q.addr), .entry(tve_data), .msi32_en(msi32_en),
        .kind(dec_kind), .levels(dec_lev), .pshift(dec_psh), .width(dec_wid),
        .shift0(dec_sh), .base0(dec_base), .pass_addr(dec_pass)
    );

    dpw_fetch_addr fa_i (
        .base(q.base), .addr(q.addr), .shift(q.shift), .width(q.width),
        .fetch_addr(mem_req_addr)
    );

    dpw_byteswap #(.BYTES(BYTES)) sw_i (.din(mem_rsp_data), .dout(word));

    always_comb begin
        d             = q;
        req_ready     = (q.st == ST_IDLE);
        mem_req_valid = (q.st == ST_FETCH);
        rsp_valid     = (q.st == ST_RESP);
        page_mask     = (64'd1 << q.pshift) - 64'd1;
        granted       = q.wr ? word[1] : word[0];
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    d.wr   = req_write;
                    d.pe   = req_pe;
                    d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                d.fault    = 1'b1;
                d.res_addr = '0;
                d.res_mask = '0;
                d.res_perm = '0;
                case (dec_kind)
                    DEC_PASS: begin
                        d.fault    = 1'b0;
                        d.res_addr = dec_pass;
                        d.res_mask = 64'hfff;
                        d.res_perm = 2'b11;
                        d.st       = ST_RESP;
                    end
                    DEC_WALK: begin
                        d.base   = dec_base;
                        d.shift  = dec_sh;
                        d.width  = dec_wid;
                        d.pshift = dec_psh;
                        d.left   = dec_lev;
                        d.st     = ST_FETCH;
                    end
                    default: d.st = ST_RESP;
                endcase
            end
            ST_FETCH: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        d.st = ST_RESP;
                    end else if (q.left != 3'd0) begin
                        if (word[1:0] == 2'b00) begin
                            d.st = ST_RESP;
                        end else begin
                            d.base  = word & ~64'hfff;
                            d.shift = q.shift - SH_W'(q.width);
                            d.left  = q.left - 3'd1;
                            d.st    = ST_FETCH;
                        end
                    end else begin
                        if (granted) begin
                            d.fault    = 1'b0;
                            d.res_addr = word & ~page_mask;
                            d.res_mask = page_mask;
                            d.res_perm = word[1:0];
                        end
                        d.st = ST_RESP;
                    end
                end
            end
            ST_RESP: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.fault <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rsp_fault = q.fault;
    assign rsp_addr  = q.res_addr;
    assign rsp_mask  = q.res_mask;
    assign rsp_perm  = q.res_perm;
endmodule

// File: rtl/dpw_checker.sv
module dpw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [63:0] mem_req_addr,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [63:0] rsp_addr,
    input logic [63:0] rsp_mask,
    input logic [1:0]  rsp_perm
);
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R12
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !rsp_valid); // R12
    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R7
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_addr == 64'd0 && rsp_mask == 64'd0 && rsp_perm == 2'd0); // R3
    AST_GRANT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_perm != 2'd0); // R9
    AST_ADDR_ON_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> (rsp_addr & rsp_mask) == 64'd0); // R10
endmodule

bind dma_page_walker dpw_checker chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_addr(rsp_addr), .rsp_mask(rsp_mask), .rsp_perm(rsp_perm)
);

// File: tb/dma_page_walker_tb_top.sv
`timescale 1ns/1ps
module dma_page_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [7:0]  req_pe = '0;
    logic        req_write = 1'b0;
    logic        msi32_en = 1'b0;
    logic [8:0]  tve_idx;
    logic [63:0] tve_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [63:0] rsp_addr;
    logic [63:0] rsp_mask;
    logic [1:0]  rsp_perm;

    logic [63:0] tve_tab [0:511];
    logic [63:0] mem [logic [63:0]];
    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    assign tve_data = tve_tab[tve_idx];

    dma_page_walker #(.PE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_pe(req_pe), .req_write(req_write),
        .msi32_en(msi32_en), .tve_idx(tve_idx), .tve_data(tve_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
        .rsp_mask(rsp_mask), .rsp_perm(rsp_perm)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] bswap(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] mk_ent(input logic [39:0] tb, input int lev,
                                           input int wf, input int ps, input bit pass);
        logic [63:0] e = '0;
        e[39:0]  = tb;
        e[42:40] = 3'(lev);
        e[47:43] = 5'(wf);
        e[56:52] = 5'(ps);
        e[51]    = pass;
        return e;
    endfunction

    // Model written from the requirements
    function automatic void ref_xlate(input logic [63:0] a, input logic [7:0] pe,
            input bit wr, input bit m32, output bit f, output logic [63:0] oa,
            output logic [63:0] om, output logic [1:0] op, output int nf,
            output logic [63:0] fa [0:7]);
        logic [63:0] e, base, ent, msk;
        int lev, ps, wf, psh, w, sh;
        f = 1'b1; oa = '0; om = '0; op = '0; nf = 0;
        for (int i = 0; i < 8; i++) fa[i] = '0;
        if (a[63:60] != 4'h0) return;
        if (m32 && a[63:16] == 48'h0000_0000_ffff) return;
        e   = tve_tab[{pe, a[59]}];
        lev = int'(e[42:40]); ps = int'(e[56:52]); wf = int'(e[47:43]);
        if (lev > 4) return;
        if (ps == 0) begin
            if (e[51]) begin
                f = 1'b0; oa = a & 64'h0003_ffff_ffff_f000; om = 64'hfff; op = 2'b11;
            end
            return;
        end
        if (wf == 0) return;
        psh = ps + 11; w = wf + 8; base = 64'(e[39:0]) << 12; sh = w * lev + psh;
        ent = '0;
        for (int i = 0; i <= lev; i++) begin
            logic [63:0] ta;
            ta = base | (((a >> sh) & ((64'd1 << w) - 1)) << 3);
            fa[nf] = ta; nf++;
            if (!mem.exists(ta)) return;
            ent = mem[ta];
            if (i < lev) begin
                if (ent[1:0] == 2'b00) return;
                base = ent & ~64'hfff; sh = sh - w;
            end
        end
        if ((wr && !ent[1]) || (!wr && !ent[0])) return;
        msk = (64'd1 << psh) - 1;
        f = 1'b0; oa = ent & ~msk; om = msk; op = ent[1:0];
    endfunction

    task automatic run(input string tag, input logic [63:0] a, input logic [7:0] pe,
                       input bit wr, input bit m32);
        bit ef; logic [63:0] ea, em; logic [1:0] ep; int enf;
        logic [63:0] efa [0:7];
        logic [63:0] got [0:7];
        int ng = 0; bit pend = 0; int dly = 0; bit done = 0; bit busy_ok = 1;
        logic [63:0] pa = '0;
        ref_xlate(a, pe, wr, m32, ef, ea, em, ep, enf, efa);
        @(negedge clk);
        msi32_en = m32; req_addr = a; req_pe = pe; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 400 && !done; c++) begin
            if (c > 0) @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
            if (rsp_valid) begin
                done = 1;
            end else begin
                if (req_ready) busy_ok = 0;
                if (pend) begin
                    if (dly == 0) begin
                        pend = 0; mem_rsp_valid = 1'b1;
                        if (mem.exists(pa)) mem_rsp_data = bswap(mem[pa]);
                        else begin mem_rsp_err = 1'b1; mem_rsp_data = $urandom; end
                    end else dly--;
                end else begin
                    mem_req_ready = ($urandom % 4) != 0;
                    if (mem_req_valid && mem_req_ready) begin
                        pa = mem_req_addr;
                        if (ng < 8) got[ng] = pa;
                        ng++; pend = 1; dly = $urandom % 3;
                    end
                end
            end
        end
        chk(tag, "response seen", 64'(done), 64'd1);
        chk("R12", "ready low while busy", 64'(busy_ok), 64'd1);
        chk(tag, "fault", 64'(rsp_fault), 64'(ef));
        chk(tag, "addr", rsp_addr, ea);
        chk(tag, "mask", rsp_mask, em);
        chk(tag, "perm", 64'(rsp_perm), 64'(ep));
        chk("R7", "fetch count", 64'(ng), 64'(enf));
        for (int i = 0; i < enf && i < ng && i < 8; i++)
            chk("R7", "fetch addr", got[i], efa[i]);
    endtask

    initial begin
        while (cycles < 150000) begin @(posedge clk); cycles++; end
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] a, e, ta;
        void'($urandom(32'd4711));
        for (int i = 0; i < 512; i++) tve_tab[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);

        // R5 pass-through and R2 descriptor select
        tve_tab[2*7]   = mk_ent(40'h0, 0, 0, 0, 1'b1);
        tve_tab[2*7+1] = mk_ent(40'h0, 0, 0, 0, 1'b0);
        run("R5", 64'h0123_4567_89ab_cdef & ~(64'd1 << 59), 8'd7, 1'b1, 1'b0);
        run("R2", 64'h0800_0000_0000_1000, 8'd7, 1'b0, 1'b0);
        // R3 address classes
        run("R3", 64'h1000_0000_0000_0000, 8'd7, 1'b0, 1'b0);
        run("R3", 64'h5000_0000_0000_0000, 8'd7, 1'b0, 1'b0);
        run("R3", 64'h0000_0000_ffff_0040, 8'd7, 1'b0, 1'b1);
        run("R5", 64'h0000_0000_ffff_0040, 8'd7, 1'b0, 1'b0);
        // R4 too many levels
        tve_tab[2*3] = mk_ent(40'h100, 5, 1, 1, 1'b0);
        run("R4", 64'h0000_0000_0010_0000, 8'd3, 1'b0, 1'b0);
        // R6 zero width field
        tve_tab[2*3] = mk_ent(40'h100, 1, 0, 1, 1'b0);
        run("R6", 64'h0000_0000_0010_0000, 8'd3, 1'b0, 1'b0);
        // R10 / R13 single-level read success, then R9 write denied
        tve_tab[2*4] = mk_ent(40'h200, 0, 1, 1, 1'b0);
        a = 64'h0000_0000_0034_5678;
        ta = (64'h200 << 12) | (((a >> 12) & 64'h1ff) << 3);
        mem[ta] = 64'h1122_3344_5566_7001;
        run("R10", a, 8'd4, 1'b0, 1'b0);
        run("R9", a, 8'd4, 1'b1, 1'b0);
        mem[ta] = 64'h1122_3344_5566_7002;
        run("R9", a, 8'd4, 1'b1, 1'b0);
        run("R13", a, 8'd4, 1'b0, 1'b0);
        // R11 missing word
        mem.delete();
        run("R11", a, 8'd4, 1'b0, 1'b0);
        // R8 intermediate zero permission
        tve_tab[2*4] = mk_ent(40'h200, 1, 1, 1, 1'b0);
        ta = (64'h200 << 12) | (((a >> 21) & 64'h1ff) << 3);
        mem[ta] = 64'h0000_0000_0030_0000;
        run("R8", a, 8'd4, 1'b0, 1'b0);

        // Random walks of 0..4 extra levels
        for (int it = 0; it < 300; it++) begin
            logic [7:0] pe; int lev, ps, wf, w, sh; logic [63:0] base, nb, ent; bit wr;
            mem.delete();
            pe = 8'($urandom); lev = $urandom % 5; ps = 1 + $urandom % 20; wf = $urandom % 4;
            if ($urandom % 10 == 0) wf = 0;
            a = {4'h0, 28'($urandom), 32'($urandom)};
            e = mk_ent(40'($urandom % (1 << 28)), lev, wf, ps, 1'b0);
            tve_tab[{pe, a[59]}] = e;
            w = wf + 8; base = 64'(e[39:0]) << 12; sh = w * lev + ps + 11;
            for (int l = 0; l <= lev; l++) begin
                int r;
                r = $urandom % 20;
                ta = base | (((a >> sh) & ((64'd1 << w) - 1)) << 3);
                if (r == 0) break;
                if (l < lev) begin
                    nb = 64'($urandom % (1 << 28)) << 12;
                    ent = nb | ((r == 1) ? 64'd0 : 64'(1 + $urandom % 3));
                    mem[ta] = ent; base = nb; sh = sh - w;
                end else begin
                    mem[ta] = {$urandom, $urandom};
                end
            end
            wr = $urandom % 2;
            run("R10", a, pe, wr, 1'($urandom % 2));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule